// File: doc/BRIEF.md
# Read-Data Parity Checker and Reporter

This block sits on one side of a two-port PCI bridge, on the path that carries read data returned by a target. For each data phase flagged by a strobe, it computes even parity over the address/data and command/byte-enable lines. It compares the result with the bus parity bit, which arrives one clock later. When the parity-error-response enable is set, a mismatch drives an active-low error output for exactly one clock, two cycles after the data phase.

Two sticky status bits record errors. One records every detected error. The other records only errors seen while the response enable is set. Each bit is cleared by writing a one to a clear input. Every data word goes out on a forwarding port toward the initiator on the opposite bus, with its original parity bit. Bad parity is passed on as received, not corrected, and the transfer completes normally. A discard input drops prefetched words that will never be read, so their bad parity never leaves the block. An error indication driven by the initiator while data is returned has no effect on the block.

Top module: `rdpar_check`

## Requirements
- R1: Expected parity is the even-parity XOR of all of `ad_i` and `cbe_i` for a phase with `dvalid_i` high in cycle T. An error is flagged when `par_i`, sampled in cycle T+1, differs from that value.
- R2: For an error, `perr_n_o` is 0 during cycle T+2 only, and only if `perr_resp_en_i` was 1 in cycle T+1. In every other case `perr_n_o` is 1.
- R3: Errors on data phases in consecutive cycles give `perr_n_o` low in consecutive cycles, one per errored phase.
- R4: `stat_det_o` becomes 1 in cycle T+2 for every detected error, whatever the value of `perr_resp_en_i`.
- R5: `stat_dpd_o` becomes 1 in cycle T+2 for an error only when `perr_resp_en_i` was 1 in cycle T+1. Otherwise it keeps its value.
- R6: Both status bits are sticky. A 1 on `stat_clr_i[0]` clears `stat_det_o` and a 1 on `stat_clr_i[1]` clears `stat_dpd_o`, one cycle later. If a set and a clear fall in the same cycle, the set wins.
- R7: In cycle T+2, `fwd_valid_o` is 1 and `fwd_ad_o`, `fwd_cbe_o` and `fwd_par_o` carry the phase's data, byte enables and the `par_i` received in T+1, unchanged even when the parity is bad. No abort or retry output exists.
- R8: If `discard_i` is 1 in cycle T or T+1, the word is not forwarded (`fwd_valid_o` stays 0 in T+2). Its error is still reported on `perr_n_o` and the status bits.
- R9: `init_perr_n_i` has no effect: with good parity, driving it low leaves `perr_n_o` at 1, the status bits at 0 and forwarding unchanged.
- R10: While `rst_n` is 0 at a clock edge, `perr_n_o` becomes 1 and `stat_det_o`, `stat_dpd_o` and `fwd_valid_o` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dvalid_i | input | 1 | A read data phase completes this cycle |
| ad_i | input | DATA_W | Address/data lines |
| cbe_i | input | DATA_W/8 | Command/byte-enable lines |
| par_i | input | 1 | Bus parity, one cycle after its data phase |
| perr_resp_en_i | input | 1 | Parity-error-response enable |
| stat_clr_i | input | 2 | Write-one-to-clear: bit 0 detected, bit 1 data-parity-detected |
| discard_i | input | 1 | Drop prefetched words in flight |
| init_perr_n_i | input | 1 | Error indication from the initiator (ignored) |
| perr_n_o | output | 1 | Active-low parity error report |
| stat_det_o | output | 1 | Sticky detected-parity-error status |
| stat_dpd_o | output | 1 | Sticky data-parity-detected status |
| fwd_valid_o | output | 1 | Forwarded word valid |
| fwd_ad_o | output | DATA_W | Forwarded data |
| fwd_cbe_o | output | DATA_W/8 | Forwarded byte enables |
| fwd_par_o | output | 1 | Forwarded original parity |

## Verification
The hardest situations to reach are the ones where two events meet on the same clock edge. One is a status set landing in the same cycle as its clear. The other is a discard arriving one cycle after the data phase, while the word is between the compare stage and the forwarding register. Directed tests place the clear pulse and the discard pulse exactly on cycle T+1 of an errored phase. They then check that the error is still reported, that the word does not appear, and that the status bit survives the clear. Back-to-back errored phases are driven with each phase's parity overlapping the next phase's data, so the one-clock-per-phase rule is tested.

// File: rtl/rdpar_pkg.sv
// Shared definitions for the read-data parity checker.
// Assumes the data width is a whole number of byte lanes.
package rdpar_pkg;
    localparam int LANE_W = 8;
    localparam int ST_DET = 0;
    localparam int ST_DPD = 1;
    localparam int ST_W   = 2;
endpackage

// File: rtl/rdpar_capture.sv
// Stage 1: registers a data phase and its computed even parity.
// The parity is folded per byte lane (data byte plus its C/BE bit), and the
// lanes are then XORed together. Assumes DATA_W = BE_W * LANE_W.
module rdpar_capture
    import rdpar_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dvalid_i,
    input  logic              discard_i,
    input  logic [DATA_W-1:0] ad_i,
    input  logic [BE_W-1:0]   cbe_i,
    output logic              s1_vld_o,
    output logic              s1_keep_o,
    output logic              s1_par_o,
    output logic [DATA_W-1:0] s1_ad_o,
    output logic [BE_W-1:0]   s1_cbe_o
);
    logic [BE_W-1:0] lane_par;

    // Per-lane parity of one data byte and its byte-enable bit.
    genvar g;
    generate
        for (g = 0; g < BE_W; g++) begin : g_lane
            assign lane_par[g] = ^{ad_i[g*LANE_W +: LANE_W], cbe_i[g]};
        end
    endgenerate

    // Capture the phase, its expected parity and whether it is still wanted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld_o  <= 1'b0;
            s1_keep_o <= 1'b0;
            s1_par_o  <= 1'b0;
            s1_ad_o   <= '0;
            s1_cbe_o  <= '0;
        end else begin
            s1_vld_o  <= dvalid_i;
            s1_keep_o <= dvalid_i & ~discard_i;
            s1_par_o  <= ^lane_par;
            s1_ad_o   <= ad_i;
            s1_cbe_o  <= cbe_i;
        end
    end
endmodule

// File: rtl/rdpar_judge.sv
// Stage 2: compares the late bus parity with the computed value, drives the
// active-low error report and loads the forwarding register. Bad parity is
// forwarded as received. Assumes par_i belongs to the phase held in stage 1.
module rdpar_judge #(
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s1_vld_i,
    input  logic              s1_keep_i,
    input  logic              s1_par_i,
    input  logic [DATA_W-1:0] s1_ad_i,
    input  logic [BE_W-1:0]   s1_cbe_i,
    input  logic              par_i,
    input  logic              resp_en_i,
    input  logic              discard_i,
    output logic              err_o,
    output logic              perr_n_o,
    output logic              fwd_valid_o,
    output logic [DATA_W-1:0] fwd_ad_o,
    output logic [BE_W-1:0]   fwd_cbe_o,
    output logic              fwd_par_o
);
    // Mismatch between the received and the computed parity.
    always_comb err_o = s1_vld_i & (s1_par_i ^ par_i);

    // One-clock error report, gated by the response enable.
    always_ff @(posedge clk) begin
        if (!rst_n) perr_n_o <= 1'b1;
        else        perr_n_o <= ~(err_o & resp_en_i);
    end

    // Forward the word with its original parity unless it was discarded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid_o <= 1'b0;
            fwd_ad_o    <= '0;
            fwd_cbe_o   <= '0;
            fwd_par_o   <= 1'b0;
        end else begin
            fwd_valid_o <= s1_vld_i & s1_keep_i & ~discard_i;
            if (s1_vld_i) begin
                fwd_ad_o  <= s1_ad_i;
                fwd_cbe_o <= s1_cbe_i;
                fwd_par_o <= par_i;
            end
        end
    end
endmodule

// File: rtl/rdpar_status.sv
// Sticky status bits with write-one-to-clear. The detected bit follows every
// error; the data-parity-detected bit only errors with the enable set.
// A set in the same cycle as a clear takes priority.
module rdpar_status
    import rdpar_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            err_i,
    input  logic            resp_en_i,
    input  logic [ST_W-1:0] clr_i,
    output logic [ST_W-1:0] stat_o
);
    logic [ST_W-1:0] set_vec;

    // Set conditions for each status bit.
    always_comb begin
        set_vec         = '0;
        set_vec[ST_DET] = err_i;
        set_vec[ST_DPD] = err_i & resp_en_i;
    end

    // Per-bit sticky register: set has priority over clear.
    genvar b;
    generate
        for (b = 0; b < ST_W; b++) begin : g_bit
            always_ff @(posedge clk) begin
                if (!rst_n) stat_o[b] <= 1'b0;
                else        stat_o[b] <= set_vec[b] | (stat_o[b] & ~clr_i[b]);
            end
        end
    endgenerate
endmodule

// File: rtl/rdpar_check.sv
// Top of the read-data parity checker: a capture stage, a compare and
// forward stage, and the sticky status. The initiator's error input is
// deliberately left without effect.
module rdpar_check
    import rdpar_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dvalid_i,
    input  logic [DATA_W-1:0] ad_i,
    input  logic [BE_W-1:0]   cbe_i,
    input  logic              par_i,
    input  logic              perr_resp_en_i,
    input  logic [1:0]        stat_clr_i,
    input  logic              discard_i,
    input  logic              init_perr_n_i,
    output logic              perr_n_o,
    output logic              stat_det_o,
    output logic              stat_dpd_o,
    output logic              fwd_valid_o,
    output logic [DATA_W-1:0] fwd_ad_o,
    output logic [BE_W-1:0]   fwd_cbe_o,
    output logic              fwd_par_o
);
    logic              s1_vld, s1_keep, s1_par, err;
    logic [DATA_W-1:0] s1_ad;
    logic [BE_W-1:0]   s1_cbe;
    logic [ST_W-1:0]   stat;

    rdpar_capture #(.DATA_W(DATA_W), .BE_W(BE_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .dvalid_i(dvalid_i), .discard_i(discard_i),
        .ad_i(ad_i), .cbe_i(cbe_i), .s1_vld_o(s1_vld), .s1_keep_o(s1_keep),
        .s1_par_o(s1_par), .s1_ad_o(s1_ad), .s1_cbe_o(s1_cbe)
    );

    rdpar_judge #(.DATA_W(DATA_W), .BE_W(BE_W)) u_judge (
        .clk(clk), .rst_n(rst_n), .s1_vld_i(s1_vld), .s1_keep_i(s1_keep),
        .s1_par_i(s1_par), .s1_ad_i(s1_ad), .s1_cbe_i(s1_cbe), .par_i(par_i),
        .resp_en_i(perr_resp_en_i), .discard_i(discard_i), .err_o(err),
        .perr_n_o(perr_n_o), .fwd_valid_o(fwd_valid_o), .fwd_ad_o(fwd_ad_o),
        .fwd_cbe_o(fwd_cbe_o), .fwd_par_o(fwd_par_o)
    );

    rdpar_status u_status (
        .clk(clk), .rst_n(rst_n), .err_i(err), .resp_en_i(perr_resp_en_i),
        .clr_i(stat_clr_i), .stat_o(stat)
    );

    // Map the status vector to named outputs.
    always_comb begin
        stat_det_o = stat[ST_DET];
        stat_dpd_o = stat[ST_DPD];
    end
endmodule

// File: rtl/rdpar_check_sva.sv
// Port-level properties of rdpar_check, attached by bind below.
module rdpar_check_sva #(
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dvalid_i,
    input logic [DATA_W-1:0] ad_i,
    input logic [BE_W-1:0]   cbe_i,
    input logic              par_i,
    input logic              perr_resp_en_i,
    input logic [1:0]        stat_clr_i,
    input logic              discard_i,
    input logic              init_perr_n_i,
    input logic              perr_n_o,
    input logic              stat_det_o,
    input logic              stat_dpd_o,
    input logic              fwd_valid_o,
    input logic [DATA_W-1:0] fwd_ad_o,
    input logic [BE_W-1:0]   fwd_cbe_o,
    input logic              fwd_par_o
);
    assert_perr_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n_o |-> $past(perr_resp_en_i));

    assert_perr_per_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n_o |-> $past(dvalid_i, 2));

    assert_detected_on_perr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n_o |-> stat_det_o);

    assert_dpd_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_dpd_o) |-> ($past(perr_resp_en_i) && stat_det_o));

    assert_forward_original_par_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid_o |-> ($past(dvalid_i, 2) && fwd_par_o == $past(par_i)));

    assert_discard_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid_o |-> (!$past(discard_i) && !$past(discard_i, 2)));

    assert_initiator_perr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(init_perr_n_i) && !$past(dvalid_i, 2)) |-> perr_n_o);
endmodule

bind rdpar_check rdpar_check_sva #(.DATA_W(DATA_W), .BE_W(BE_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .dvalid_i(dvalid_i), .ad_i(ad_i), .cbe_i(cbe_i),
    .par_i(par_i), .perr_resp_en_i(perr_resp_en_i), .stat_clr_i(stat_clr_i),
    .discard_i(discard_i), .init_perr_n_i(init_perr_n_i), .perr_n_o(perr_n_o),
    .stat_det_o(stat_det_o), .stat_dpd_o(stat_dpd_o), .fwd_valid_o(fwd_valid_o),
    .fwd_ad_o(fwd_ad_o), .fwd_cbe_o(fwd_cbe_o), .fwd_par_o(fwd_par_o)
);

// File: tb/rdpar_check_test.sv
module rdpar_check_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dvalid_i = 1'b0;
    logic [31:0] ad_i = '0;
    logic [3:0]  cbe_i = '0;
    logic        par_i = 1'b0;
    logic        perr_resp_en_i = 1'b0;
    logic [1:0]  stat_clr_i = '0;
    logic        discard_i = 1'b0;
    logic        init_perr_n_i = 1'b1;
    logic        perr_n_o, stat_det_o, stat_dpd_o, fwd_valid_o, fwd_par_o;
    logic [31:0] fwd_ad_o;
    logic [3:0]  fwd_cbe_o;

    int tests = 0;
    int fails = 0;

    rdpar_check #(.DATA_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .dvalid_i(dvalid_i), .ad_i(ad_i), .cbe_i(cbe_i),
        .par_i(par_i), .perr_resp_en_i(perr_resp_en_i), .stat_clr_i(stat_clr_i),
        .discard_i(discard_i), .init_perr_n_i(init_perr_n_i), .perr_n_o(perr_n_o),
        .stat_det_o(stat_det_o), .stat_dpd_o(stat_dpd_o), .fwd_valid_o(fwd_valid_o),
        .fwd_ad_o(fwd_ad_o), .fwd_cbe_o(fwd_cbe_o), .fwd_par_o(fwd_par_o)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic [31:0] ad;
        logic [3:0]  cbe;
        logic        flip;
        logic        en;
        logic [1:0]  disc;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'h0000_0000, 4'h0, 1'b0, 1'b1, 2'd0},
        '{32'hFFFF_FFFF, 4'hF, 1'b1, 1'b1, 2'd0},
        '{32'hA5A5_A5A5, 4'h3, 1'b1, 1'b0, 2'd0},
        '{32'h1234_5678, 4'h6, 1'b0, 1'b0, 2'd0},
        '{32'h8000_0001, 4'h8, 1'b1, 1'b1, 2'd1},
        '{32'hDEAD_BEEF, 4'hC, 1'b1, 1'b1, 2'd2},
        '{32'h0000_0001, 4'h0, 1'b0, 1'b1, 2'd2},
        '{32'h7FFF_FFFE, 4'h1, 1'b1, 1'b1, 2'd0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one word: data in T, parity (optionally flipped) in T+1, then
    // stop at the falling edge inside T+2.
    task automatic send(input logic [31:0] ad, input logic [3:0] cbe, input logic flip,
                        input logic en, input logic [1:0] disc, input logic [1:0] clr_t1);
        @(negedge clk);
        dvalid_i = 1'b1; ad_i = ad; cbe_i = cbe; perr_resp_en_i = en;
        discard_i = (disc == 2'd1);
        @(negedge clk);
        dvalid_i = 1'b0; par_i = (^{ad, cbe}) ^ flip;
        discard_i = (disc == 2'd2); stat_clr_i = clr_t1;
        @(negedge clk);
        discard_i = 1'b0; stat_clr_i = 2'b00;
    endtask

    task automatic clear_status();
        stat_clr_i = 2'b11;
        @(negedge clk);
        stat_clr_i = 2'b00;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 perr_n", perr_n_o, 1);
        chk("R10 det", stat_det_o, 0);
        chk("R10 dpd", stat_dpd_o, 0);
        chk("R10 fwd_valid", fwd_valid_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector walk: R1, R2, R4, R5, R7, R8
        for (int i = 0; i < 8; i++) begin
            vec_t v = VECS[i];
            logic exp_par = (^{v.ad, v.cbe}) ^ v.flip;
            send(v.ad, v.cbe, v.flip, v.en, v.disc, 2'b00);
            chk("R1/R2 perr_n", perr_n_o, !(v.flip && v.en));
            chk("R4 det", stat_det_o, v.flip);
            chk("R5 dpd", stat_dpd_o, v.flip && v.en);
            chk("R7/R8 fwd_valid", fwd_valid_o, v.disc == 2'd0);
            if (v.disc == 2'd0) begin
                chk("R7 fwd_ad", fwd_ad_o, v.ad);
                chk("R7 fwd_cbe", fwd_cbe_o, v.cbe);
                chk("R7 fwd_par", fwd_par_o, exp_par);
            end
            clear_status();
            chk("R2 perr_n one clock", perr_n_o, 1);
            chk("R6 cleared det", stat_det_o, 0);
            chk("R6 cleared dpd", stat_dpd_o, 0);
        end

        // R3: back-to-back errored phases
        @(negedge clk);
        perr_resp_en_i = 1'b1;
        dvalid_i = 1'b1; ad_i = 32'h0F0F_0F0F; cbe_i = 4'h1;
        @(negedge clk);
        par_i = ~(^{32'h0F0F_0F0F, 4'h1});
        ad_i = 32'h3333_0000; cbe_i = 4'h2;
        @(negedge clk);
        dvalid_i = 1'b0; par_i = ~(^{32'h3333_0000, 4'h2});
        chk("R3 first perr", perr_n_o, 0);
        @(negedge clk);
        chk("R3 second perr", perr_n_o, 0);
        @(negedge clk);
        chk("R3 released", perr_n_o, 1);
        clear_status();

        // R6: sticky hold, then set wins against a same-cycle clear
        send(32'h0000_00FF, 4'h0, 1'b1, 1'b1, 2'd0, 2'b00);
        repeat (3) @(negedge clk);
        chk("R6 sticky det", stat_det_o, 1);
        chk("R6 sticky dpd", stat_dpd_o, 1);
        stat_clr_i = 2'b01;
        @(negedge clk);
        stat_clr_i = 2'b00;
        chk("R6 clr bit0 only det", stat_det_o, 0);
        chk("R6 clr bit0 keeps dpd", stat_dpd_o, 1);
        clear_status();
        send(32'h1111_1111, 4'h5, 1'b1, 1'b1, 2'd0, 2'b11);
        chk("R6 set wins det", stat_det_o, 1);
        chk("R6 set wins dpd", stat_dpd_o, 1);
        clear_status();

        // R9: initiator error input has no effect
        init_perr_n_i = 1'b0;
        send(32'hCAFE_F00D, 4'h9, 1'b0, 1'b1, 2'd0, 2'b00);
        chk("R9 perr_n", perr_n_o, 1);
        chk("R9 det", stat_det_o, 0);
        chk("R9 fwd_valid", fwd_valid_o, 1);
        chk("R9 fwd_ad", fwd_ad_o, 32'hCAFE_F00D);
        init_perr_n_i = 1'b1;

        // R10: reset in mid-operation
        send(32'h0000_0003, 4'h0, 1'b1, 1'b1, 2'd0, 2'b00);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 mid perr_n", perr_n_o, 1);
        chk("R10 mid det", stat_det_o, 0);
        chk("R10 mid fwd_valid", fwd_valid_o, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule